// File: doc/BRIEF.md
# ADC Interrupt Flag Aggregator

This block gathers the event flags of a two-sequence, twelve-channel analog-to-digital converter controller and turns them into interrupt and DMA request lines. Event pulses arrive from the surrounding converter logic: conversion completions, sequence completions, threshold hits per channel, and overruns per channel and per sequence. Clearing arrives two ways. Software can write ones to the flags register. Reading a data register also clears the flags that belong to it.

Each sequence has a flag whose meaning depends on that sequence's mode input. In per-conversion mode the flag follows a hidden data-valid bit, which a global data read clears. In end-of-sequence mode the flag latches on sequence completion and software clears it with a write-one-to-clear. Two summary bits sit above the per-channel flags, one for thresholds and one for overruns. Each summary bit stays high while any of its contributors is set. The four request outputs are registered copies of the flags, masked by an enable register.

Every stored flag is its own two-state machine. `FL_IDLE` moves to `FL_PEND` when the flag's set event arrives. `FL_PEND` moves back to `FL_IDLE` when a clear arrives in a cycle with no set event. In every other case the machine stays where it is.

Top module: `adc_irq_flag_agg`

## Requirements
- R1: After reset, `flags_rd`, `seq_irq`, `thr_irq`, `ovr_irq` and the enable register are all 0.
- R2: With `seq_mode[s]`=0, flag bit 28+s (A at 28, B at 29) is set by `conv_done[s]` and cleared by `gdat_rd[s]`.
- R3: With `seq_mode[s]`=1, flag bit 28+s shows a latch. The latch is set by `seq_done[s]` and cleared by writing a 1 to bit 28+s. In this mode `conv_done[s]` and `gdat_rd[s]` leave the shown flag unchanged.
- R4: With `seq_mode[s]`=0, writing a 1 to bit 28+s leaves that flag unchanged.
- R5: Flag bit c (c in 0..11) is set by `thr_range_evt[c]` when enable bit 2+2c is 1, and by `thr_cross_evt[c]` when enable bit 3+2c is 1. An event of a disabled type is ignored. Writing a 1 to bit c clears it.
- R6: Flag bit 30 is 1 exactly while any of bits 11:0 is 1, so it stays set until the last of them is cleared.
- R7: Flag bit 12+c is set by `ch_ovr_evt[c]` and cleared by `chdat_rd[c]`. Flag bit 31 is 1 while any bit 23:12 is 1, or while a sequence in mode 0 holds a pending global overrun. A global overrun is set by `seq_ovr_evt[s]` and cleared by `gdat_rd[s]`. While that sequence is in mode 1, its global overrun does not count towards bit 31.
- R8: If a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: The request outputs are registered and follow their conditions one cycle late. The conditions are:
  - `seq_irq[s]` = bit 28+s AND enable bit s.
  - `thr_irq` = any set channel flag c whose enable bit 2+2c or 3+2c is 1.
  - `ovr_irq` = bit 31 AND enable bit 26.
- R10: A write with `wr_sel`=1 loads the enable register from `wr_data`. A write with `wr_sel`=0 is a write-one-to-clear of the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_mode | input | 2 | Per-sequence mode: 0 per conversion, 1 end of sequence |
| conv_done | input | 2 | Conversion-complete pulse per sequence |
| seq_done | input | 2 | Sequence-complete pulse per sequence |
| thr_range_evt | input | 12 | Out-of-range threshold event per channel |
| thr_cross_evt | input | 12 | Threshold-crossing event per channel |
| ch_ovr_evt | input | 12 | Channel data register overrun pulse |
| seq_ovr_evt | input | 2 | Global data register overrun pulse per sequence |
| gdat_rd | input | 2 | Global data register read strobe per sequence |
| chdat_rd | input | 12 | Channel data register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flags (write one to clear), 1 enable |
| wr_data | input | 32 | Write data |
| flags_rd | output | 32 | Flags register read value |
| seq_irq | output | 2 | Per-sequence interrupt/DMA request |
| thr_irq | output | 1 | Threshold interrupt |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The bench first checks the mode swap. A design that ignored the mode would clear an end-of-sequence flag on a data read. It would also let a write-one-to-clear hit a mirrored flag, or keep counting a global overrun after its sequence had left per-conversion mode. Two flags are cleared one at a time, and the bench checks that the threshold summary holds until the last one goes; a summary built from the wrong bits would drop early. The bench lands a set and a clear in the same cycle, which catches a design that lets the clear win and loses the event. It also checks the per-type enables and the one-cycle lag of the requests, which catches an unregistered or unmasked request path.

// File: rtl/aif_pkg.sv
package aif_pkg;
    parameter int NUM_CH  = 12;
    parameter int NUM_SEQ = 2;
    parameter int DATA_W  = 32;

    localparam int OVR_LSB   = NUM_CH;
    localparam int SEQ_LSB   = DATA_W - 4;
    localparam int THR_SUM   = DATA_W - 2;
    localparam int OVR_SUM   = DATA_W - 1;
    localparam int EN_THR_LSB = NUM_SEQ;
    localparam int EN_OVR    = NUM_SEQ + 2 * NUM_CH;
    localparam int EN_W      = EN_OVR + 1;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/aif_flag_cell.sv
module aif_flag_cell
    import aif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (set_i)            state_d = FL_PEND;
            FL_PEND: if (clr_i && !set_i)  state_d = FL_IDLE;
            default:                       state_d = FL_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FL_PEND);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/aif_irq_stage.sv
module aif_irq_stage
    import aif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEQ-1:0] seq_flag_i,
    input  logic [NUM_CH-1:0]  thr_flag_i,
    input  logic               ovr_sum_i,
    input  logic [EN_W-1:0]    en_i,
    output logic [NUM_SEQ-1:0] seq_irq_o,
    output logic               thr_irq_o,
    output logic               ovr_irq_o
);
    logic [NUM_CH-1:0] thr_live;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_thr_gate
        assign thr_live[c] = thr_flag_i[c] &
                             (en_i[EN_THR_LSB + 2*c] | en_i[EN_THR_LSB + 2*c + 1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_irq_o <= '0;
            thr_irq_o <= 1'b0;
            ovr_irq_o <= 1'b0;
        end else begin
            seq_irq_o <= seq_flag_i & en_i[NUM_SEQ-1:0];
            thr_irq_o <= |thr_live;
            ovr_irq_o <= ovr_sum_i & en_i[EN_OVR];
        end
    end

    a_r9_thr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag_i == '0) |=> !thr_irq_o);
    a_r9_ovr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_sum_i |=> !ovr_irq_o);
endmodule

// File: rtl/adc_irq_flag_agg.sv
module adc_irq_flag_agg
    import aif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEQ-1:0] seq_mode,
    input  logic [NUM_SEQ-1:0] conv_done,
    input  logic [NUM_SEQ-1:0] seq_done,
    input  logic [NUM_CH-1:0]  thr_range_evt,
    input  logic [NUM_CH-1:0]  thr_cross_evt,
    input  logic [NUM_CH-1:0]  ch_ovr_evt,
    input  logic [NUM_SEQ-1:0] seq_ovr_evt,
    input  logic [NUM_SEQ-1:0] gdat_rd,
    input  logic [NUM_CH-1:0]  chdat_rd,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  flags_rd,
    output logic [NUM_SEQ-1:0] seq_irq,
    output logic               thr_irq,
    output logic               ovr_irq
);
    logic [EN_W-1:0]    en_q;
    logic               w1c;
    logic [NUM_CH-1:0]  thr_flag, chovr_flag;
    logic [NUM_SEQ-1:0] dv_flag, seql_flag, govr_flag, seq_flag;
    logic               thr_sum, ovr_sum;
    logic               unused_wr;

    assign w1c       = wr_en && !wr_sel;
    assign unused_wr = ^wr_data[DATA_W-1:EN_W];

    // R10: enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                en_q <= '0;
        else if (wr_en && wr_sel)  en_q <= wr_data[EN_W-1:0];
    end

    // R5 / R7: per-channel threshold and overrun flags
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic thr_set;
        assign thr_set = (thr_range_evt[c] & en_q[EN_THR_LSB + 2*c]) |
                         (thr_cross_evt[c] & en_q[EN_THR_LSB + 2*c + 1]);

        aif_flag_cell u_thr (
            .clk(clk), .rst_n(rst_n),
            .set_i(thr_set), .clr_i(w1c & wr_data[c]),
            .flag_o(thr_flag[c]));

        aif_flag_cell u_ovr (
            .clk(clk), .rst_n(rst_n),
            .set_i(ch_ovr_evt[c]), .clr_i(chdat_rd[c]),
            .flag_o(chovr_flag[c]));

        a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (chdat_rd[c] && !ch_ovr_evt[c]) |=> !flags_rd[OVR_LSB + c]);
    end

    // R2 / R3 / R4: per-sequence flags with mode-dependent meaning
    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
        aif_flag_cell u_dv (
            .clk(clk), .rst_n(rst_n),
            .set_i(conv_done[s]), .clr_i(gdat_rd[s]),
            .flag_o(dv_flag[s]));

        aif_flag_cell u_latch (
            .clk(clk), .rst_n(rst_n),
            .set_i(seq_done[s] & seq_mode[s]), .clr_i(w1c & wr_data[SEQ_LSB + s]),
            .flag_o(seql_flag[s]));

        aif_flag_cell u_govr (
            .clk(clk), .rst_n(rst_n),
            .set_i(seq_ovr_evt[s]), .clr_i(gdat_rd[s]),
            .flag_o(govr_flag[s]));

        assign seq_flag[s] = seq_mode[s] ? seql_flag[s] : dv_flag[s];

        a_r3_latch_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_mode[s] && seq_done[s]) |=> (!seq_mode[s] || flags_rd[SEQ_LSB + s]));
        a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (!seq_mode[s] && gdat_rd[s] && !conv_done[s]) |=>
                (seq_mode[s] || !flags_rd[SEQ_LSB + s]));
    end

    // R6 / R7: summary bits
    assign thr_sum = |thr_flag;
    assign ovr_sum = (|chovr_flag) | (|(govr_flag & ~seq_mode));

    always_comb begin
        flags_rd = '0;
        flags_rd[NUM_CH-1:0]                 = thr_flag;
        flags_rd[OVR_LSB +: NUM_CH]          = chovr_flag;
        flags_rd[SEQ_LSB +: NUM_SEQ]         = seq_flag;
        flags_rd[THR_SUM]                    = thr_sum;
        flags_rd[OVR_SUM]                    = ovr_sum;
    end

    a_r6_sum_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag != '0 && !wr_en) |=> flags_rd[THR_SUM]);

    // R9: registered requests
    aif_irq_stage u_irq (
        .clk(clk), .rst_n(rst_n),
        .seq_flag_i(seq_flag), .thr_flag_i(thr_flag), .ovr_sum_i(ovr_sum),
        .en_i(en_q),
        .seq_irq_o(seq_irq), .thr_irq_o(thr_irq), .ovr_irq_o(ovr_irq));

    a_r9_seq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd[SEQ_LSB] && en_q[0]) |=> seq_irq[0]);
endmodule

// File: tb/adc_irq_flag_agg_tb.sv
module adc_irq_flag_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  seq_mode = '0, conv_done = '0, seq_done = '0, seq_ovr_evt = '0, gdat_rd = '0;
    logic [11:0] thr_range_evt = '0, thr_cross_evt = '0, ch_ovr_evt = '0, chdat_rd = '0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] flags_rd;
    logic [1:0]  seq_irq;
    logic        thr_irq, ovr_irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_irq_flag_agg dut_i (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  cd;
        logic [1:0]  sd;
        logic [11:0] trng;
        logic [11:0] tcrs;
        logic [11:0] covr;
        logic [1:0]  sovr;
        logic [1:0]  grd;
        logic [11:0] drd;
        logic        w1c;
        logic [31:0] wdat;
        logic [31:0] eflags;
        logic [3:0]  eirq;   // {ovr, thr, seqB, seqA}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        // R2: A mirrors conversion done, cleared by global read
        '{2'b00,2'b01,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h1000_0000,4'b0001,8'd2},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b01,12'h0,1'b0,32'h0,32'h0000_0000,4'b0000,8'd2},
        // R3: latch on sequence done, read ignored, W1C clears
        '{2'b01,2'b00,2'b01,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h1000_0000,4'b0001,8'd3},
        '{2'b01,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b01,12'h0,1'b0,32'h0,32'h1000_0000,4'b0001,8'd3},
        '{2'b01,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b1,32'h1000_0000,32'h0,4'b0000,8'd3},
        // R4: B in mode 0 ignores W1C
        '{2'b00,2'b10,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h2000_0000,4'b0010,8'd2},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b1,32'h2000_0000,32'h2000_0000,4'b0010,8'd4},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b10,12'h0,1'b0,32'h0,32'h0,4'b0000,8'd2},
        // R5 / R6: two threshold flags, summary holds until last clear
        '{2'b00,2'b00,2'b00,12'h008,12'h400,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h4000_0408,4'b0100,8'd5},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b1,32'h0000_0008,32'h4000_0400,4'b0100,8'd6},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b1,32'h0000_0400,32'h0,4'b0000,8'd6},
        // R7: channel overrun and global overrun by mode
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h020,2'b00,2'b00,12'h0,1'b0,32'h0,32'h8002_0000,4'b1000,8'd7},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h020,1'b0,32'h0,32'h0,4'b0000,8'd7},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b01,2'b00,12'h0,1'b0,32'h0,32'h8000_0000,4'b1000,8'd7},
        '{2'b01,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h0,4'b0000,8'd7},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b01,12'h0,1'b0,32'h0,32'h0,4'b0000,8'd7},
        // R8: set and clear in one cycle
        '{2'b00,2'b00,2'b00,12'h001,12'h0,12'h0,2'b00,2'b00,12'h0,1'b1,32'h0000_0001,32'h4000_0001,4'b0100,8'd8},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b1,32'h0000_0001,32'h0,4'b0000,8'd5},
        '{2'b00,2'b01,2'b00,12'h0,12'h0,12'h0,2'b00,2'b01,12'h0,1'b0,32'h0,32'h1000_0000,4'b0001,8'd8},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b01,12'h0,1'b0,32'h0,32'h0,4'b0000,8'd2},
        // R3: conversion done hidden in mode 1, shown again in mode 0
        '{2'b01,2'b01,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h0,4'b0000,8'd3},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b00,12'h0,1'b0,32'h0,32'h1000_0000,4'b0001,8'd2},
        '{2'b00,2'b00,2'b00,12'h0,12'h0,12'h0,2'b00,2'b01,12'h0,1'b0,32'h0,32'h0,4'b0000,8'd2}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_pulses();
        conv_done = '0; seq_done = '0; thr_range_evt = '0; thr_cross_evt = '0;
        ch_ovr_evt = '0; seq_ovr_evt = '0; gdat_rd = '0; chdat_rd = '0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic write_en(input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = val;
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(flags_rd == 32'h0, "R1 flags", flags_rd, 32'h0);
        check({ovr_irq, thr_irq, seq_irq} == 4'b0, "R1 irq", {28'h0, ovr_irq, thr_irq, seq_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: enable register starts clear, so a flag raises no request
        conv_done = 2'b01;
        @(negedge clk); clear_pulses();
        @(negedge clk);
        check(seq_irq == 2'b00, "R1 enable reset", {30'h0, seq_irq}, 32'h0);
        gdat_rd = 2'b01;
        @(negedge clk); clear_pulses();

        // R10: enable all request sources
        write_en(32'h07FF_FFFF);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            seq_mode = VECS[i].mode; conv_done = VECS[i].cd; seq_done = VECS[i].sd;
            thr_range_evt = VECS[i].trng; thr_cross_evt = VECS[i].tcrs;
            ch_ovr_evt = VECS[i].covr; seq_ovr_evt = VECS[i].sovr;
            gdat_rd = VECS[i].grd; chdat_rd = VECS[i].drd;
            wr_en = VECS[i].w1c; wr_sel = 1'b0; wr_data = VECS[i].wdat;
            @(negedge clk);
            clear_pulses();
            check(flags_rd == VECS[i].eflags, $sformatf("R%0d flags vec %0d", VECS[i].req, i),
                  flags_rd, VECS[i].eflags);
            @(negedge clk);
            check({ovr_irq, thr_irq, seq_irq} == VECS[i].eirq, $sformatf("R9 irq vec %0d", i),
                  {28'h0, ovr_irq, thr_irq, seq_irq}, {28'h0, VECS[i].eirq});
        end

        // R5 / R10: only crossing type on channel 2 enabled (enable bit 7)
        seq_mode = 2'b00;
        write_en(32'h0000_0080);
        @(negedge clk); thr_range_evt = 12'h004;
        @(negedge clk); clear_pulses();
        check(flags_rd == 32'h0, "R5 disabled type ignored", flags_rd, 32'h0);
        thr_cross_evt = 12'h004;
        @(negedge clk); clear_pulses();
        check(flags_rd == 32'h4000_0004, "R5 enabled type sets", flags_rd, 32'h4000_0004);
        check(thr_irq == 1'b0, "R9 request one cycle late", {31'h0, thr_irq}, 32'h0);
        @(negedge clk);
        check(thr_irq == 1'b1, "R9 threshold request", {31'h0, thr_irq}, 32'h1);
        wr_en = 1'b1; wr_data = 32'h0000_0004;
        @(negedge clk); clear_pulses();
        check(flags_rd == 32'h0, "R5 W1C clears", flags_rd, 32'h0);
        check(thr_irq == 1'b1, "R9 request drops one cycle late", {31'h0, thr_irq}, 32'h1);
        @(negedge clk);
        check(thr_irq == 1'b0, "R9 threshold request low", {31'h0, thr_irq}, 32'h0);

        // R9: sequence A enable off
        conv_done = 2'b01;
        @(negedge clk); clear_pulses();
        @(negedge clk);
        check(flags_rd == 32'h1000_0000, "R2 flag set while masked", flags_rd, 32'h1000_0000);
        check(seq_irq == 2'b00, "R9 masked sequence request", {30'h0, seq_irq}, 32'h0);
        gdat_rd = 2'b01;
        @(negedge clk); clear_pulses();

        // R9: overrun enable off
        ch_ovr_evt = 12'h001;
        @(negedge clk); clear_pulses();
        @(negedge clk);
        check(flags_rd == 32'h8000_1000, "R7 channel 0 overrun", flags_rd, 32'h8000_1000);
        check(ovr_irq == 1'b0, "R9 masked overrun request", {31'h0, ovr_irq}, 32'h0);

        // R1: reset mid-run clears pending flags
        rst_n = 1'b0;
        @(negedge clk);
        check(flags_rd == 32'h0, "R1 reset clears flags", flags_rd, 32'h0);
        check({ovr_irq, thr_irq, seq_irq} == 4'b0, "R1 reset clears requests",
              {28'h0, ovr_irq, thr_irq, seq_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule